// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds a set of sticky flags that tell software why the device last came out of reset and which low-power state it last entered. Hardware event pulses from the reset and power-management logic set individual flags. A power-on event returns the whole register to a known state. Software reads the flags through a 16-bit port and may rewrite them at will. Writing a flag never starts a reset, because the block has no reset output.

The register also holds two software enable bits, one for the watchdog and one for brown-out detection. The block combines each with a 2-bit configuration code to give an effective enable. The watchdog code can force the watchdog on whatever software has written. The brown-out code decides whether the software bit is honoured at all.

The block only latches, clears and reports. Reset generation, the watchdog counter and power-mode sequencing belong to other blocks.

Top module: `rcause_status`

## Requirements
- R1: When `rst_n` is low at a clock edge, or `evt_por` is high at a clock edge, the register becomes 0x0003. Bit 0 (power-on) and bit 1 (brown-out) are set and every other bit is 0, including the enable bits 5 and 13. The power-on event overrides every other input in that cycle.
- R2: `evt_bor` sets bit 1 and no other bit.
- R3: Single-cause flags: `evt_trap_clash` sets bit 15, `evt_bad_opcode` sets bit 14, `evt_cfg_mismatch` sets bit 9, `evt_pin_rst` sets bit 7 and `evt_sw_rst` sets bit 6. Each stays set until a power-on event or a software write.
- R4: `evt_wdt_expire` sets bit 4. `evt_wdt_kick` clears bit 4, and so does any `evt_power_save`. If an expiry arrives in the same cycle as one of these clears, the expiry wins.
- R5: `evt_power_save` with `power_save_mode` = 0 sets bit 3 (sleep). With `power_save_mode` = 1 it sets bit 2 (idle). Only power-on or a software write clears these bits.
- R6: With `wr_en` high, every implemented bit takes the value of `wr_data` at the next clock edge. Setting bit 0 in this way changes no other bit.
- R7: If a hardware set event and a software write hit the same flag in one cycle, the flag ends at 1.
- R8: Bits 8, 10, 11 and 12 are unimplemented. They always read 0 and writes to them have no effect.
- R9: `wdt_enable` is 1 when `cfg_wdt_mode` = 2'b11. Otherwise it equals bit 5.
- R10: `bor_sw_enable` equals bit 13 when `cfg_bor_mode` = 2'b01. Otherwise it is 0.
- R11: `rd_data` always shows the current register contents, so the effect of a write or event is visible one clock edge after it.
- R12: With no event, no write and no power-on, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, same effect as a power-on event |
| evt_por | input | 1 | Power-on reset event pulse |
| evt_bor | input | 1 | Brown-out reset event pulse |
| evt_pin_rst | input | 1 | External reset pin event pulse |
| evt_sw_rst | input | 1 | Software reset instruction event pulse |
| evt_wdt_expire | input | 1 | Watchdog time-out event pulse |
| evt_trap_clash | input | 1 | Trap conflict event pulse |
| evt_bad_opcode | input | 1 | Illegal opcode or uninitialised working-register access pulse |
| evt_cfg_mismatch | input | 1 | Configuration mismatch event pulse |
| evt_power_save | input | 1 | Power-save command pulse |
| power_save_mode | input | 1 | Power-save operand: 0 sleep, 1 idle |
| evt_wdt_kick | input | 1 | Watchdog clear command pulse |
| cfg_wdt_mode | input | 2 | Watchdog configuration code (11 forces enable) |
| cfg_bor_mode | input | 2 | Brown-out configuration code (01 honours software bit) |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Register contents |
| wdt_enable | output | 1 | Effective watchdog enable |
| bor_sw_enable | output | 1 | Effective software brown-out enable |

## Verification
The main function is tried with one event at a time from a cleared register, to show that each event reaches only its own bit. It is then tried with events in the same cycle as writes or clears, to show which input has priority. Writes of all ones and of single bits show which positions are implemented, and that a write of bit 0 leaves the other flags alone. All four codes of each configuration field are combined with both values of the enable bit, which separates a forced enable from an honoured one.

// File: rtl/rcause_pkg.sv
// Package: bit positions, implemented mask and configuration codes shared by
// the reset cause status register and its checker. Assumes a 16-bit register.
package rcause_pkg;
    localparam int REG_W = 16;

    localparam int B_POR    = 0;
    localparam int B_BOR    = 1;
    localparam int B_IDLE   = 2;
    localparam int B_SLEEP  = 3;
    localparam int B_WDTO   = 4;
    localparam int B_WDTSW  = 5;
    localparam int B_SWRST  = 6;
    localparam int B_PINRST = 7;
    localparam int B_CFGMIS = 9;
    localparam int B_BORSW  = 13;
    localparam int B_BADOP  = 14;
    localparam int B_TRAP   = 15;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << B_POR)   | (REG_W'(1) << B_BOR)    | (REG_W'(1) << B_IDLE)   |
        (REG_W'(1) << B_SLEEP) | (REG_W'(1) << B_WDTO)   | (REG_W'(1) << B_WDTSW)  |
        (REG_W'(1) << B_SWRST) | (REG_W'(1) << B_PINRST) | (REG_W'(1) << B_CFGMIS) |
        (REG_W'(1) << B_BORSW) | (REG_W'(1) << B_BADOP)  | (REG_W'(1) << B_TRAP);

    localparam logic [REG_W-1:0] POR_VALUE = (REG_W'(1) << B_POR) | (REG_W'(1) << B_BOR);

    localparam logic [1:0] WDT_CFG_FORCE = 2'b11;
    localparam logic [1:0] BOR_CFG_SW    = 2'b01;
endpackage

// File: rtl/rcause_event_map.sv
// Event map: turns the hardware event pulses into per-bit set and clear
// vectors. Purely combinational. Assumes each pulse lasts one clock cycle.
module rcause_event_map
    import rcause_pkg::*;
(
    input  logic             evt_bor,
    input  logic             evt_pin_rst,
    input  logic             evt_sw_rst,
    input  logic             evt_wdt_expire,
    input  logic             evt_trap_clash,
    input  logic             evt_bad_opcode,
    input  logic             evt_cfg_mismatch,
    input  logic             evt_power_save,
    input  logic             power_save_mode,
    input  logic             evt_wdt_kick,
    output logic [REG_W-1:0] set_vec,
    output logic [REG_W-1:0] clr_vec
);
    // Build the set vector from the cause events.
    always_comb begin
        set_vec           = '0;
        set_vec[B_BOR]    = evt_bor;
        set_vec[B_PINRST] = evt_pin_rst;
        set_vec[B_SWRST]  = evt_sw_rst;
        set_vec[B_WDTO]   = evt_wdt_expire;
        set_vec[B_TRAP]   = evt_trap_clash;
        set_vec[B_BADOP]  = evt_bad_opcode;
        set_vec[B_CFGMIS] = evt_cfg_mismatch;
        set_vec[B_SLEEP]  = evt_power_save & ~power_save_mode;
        set_vec[B_IDLE]   = evt_power_save &  power_save_mode;
    end

    // Only the watchdog flag has a hardware clear other than power-on.
    always_comb begin
        clr_vec         = '0;
        clr_vec[B_WDTO] = evt_wdt_kick | evt_power_save;
    end
endmodule

// File: rtl/rcause_flag_cell.sv
// Flag cell: one sticky status bit. The priority, highest first, is power-on
// value, hardware set, hardware clear, software write, then hold.
// Assumes a synchronous active-low reset that loads the power-on value.
module rcause_flag_cell #(
    parameter logic POR_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic sw_we,
    input  logic sw_d,
    output logic q
);
    // Update the flag by fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n || por) q <= POR_VAL;
        else if (hw_set)   q <= 1'b1;
        else if (hw_clr)   q <= 1'b0;
        else if (sw_we)    q <= sw_d;
    end
endmodule

// File: rtl/rcause_cfg_resolve.sv
// Configuration resolve: merges the software enable bits with their
// configuration codes. Combinational. Assumes codes are static or slow-changing.
module rcause_cfg_resolve
    import rcause_pkg::*;
(
    input  logic       wdt_sw_bit,
    input  logic       bor_sw_bit,
    input  logic [1:0] cfg_wdt_mode,
    input  logic [1:0] cfg_bor_mode,
    output logic       wdt_enable,
    output logic       bor_sw_enable
);
    // The forcing code overrides the software watchdog bit.
    always_comb wdt_enable = (cfg_wdt_mode == WDT_CFG_FORCE) | wdt_sw_bit;

    // The software brown-out bit only counts when the code selects software control.
    always_comb bor_sw_enable = (cfg_bor_mode == BOR_CFG_SW) & bor_sw_bit;
endmodule

// File: rtl/rcause_status.sv
// Reset cause status register top. It instantiates one flag cell per
// implemented bit, ties unimplemented bits to 0 and resolves effective enables.
// Assumes event inputs are synchronous to clk.
module rcause_status
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_por,
    input  logic             evt_bor,
    input  logic             evt_pin_rst,
    input  logic             evt_sw_rst,
    input  logic             evt_wdt_expire,
    input  logic             evt_trap_clash,
    input  logic             evt_bad_opcode,
    input  logic             evt_cfg_mismatch,
    input  logic             evt_power_save,
    input  logic             power_save_mode,
    input  logic             evt_wdt_kick,
    input  logic [1:0]       cfg_wdt_mode,
    input  logic [1:0]       cfg_bor_mode,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             wdt_enable,
    output logic             bor_sw_enable
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] flag_q;

    rcause_event_map u_map (
        .evt_bor          (evt_bor),
        .evt_pin_rst      (evt_pin_rst),
        .evt_sw_rst       (evt_sw_rst),
        .evt_wdt_expire   (evt_wdt_expire),
        .evt_trap_clash   (evt_trap_clash),
        .evt_bad_opcode   (evt_bad_opcode),
        .evt_cfg_mismatch (evt_cfg_mismatch),
        .evt_power_save   (evt_power_save),
        .power_save_mode  (power_save_mode),
        .evt_wdt_kick     (evt_wdt_kick),
        .set_vec          (set_vec),
        .clr_vec          (clr_vec)
    );

    // One cell per implemented position; the rest are constant 0.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_cell
            rcause_flag_cell #(.POR_VAL(POR_VALUE[i])) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .por    (evt_por),
                .hw_set (set_vec[i]),
                .hw_clr (clr_vec[i]),
                .sw_we  (wr_en),
                .sw_d   (wr_data[i]),
                .q      (flag_q[i])
            );
        end else begin : g_tie
            assign flag_q[i] = 1'b0;
        end
    end

    rcause_cfg_resolve u_cfg (
        .wdt_sw_bit    (flag_q[B_WDTSW]),
        .bor_sw_bit    (flag_q[B_BORSW]),
        .cfg_wdt_mode  (cfg_wdt_mode),
        .cfg_bor_mode  (cfg_bor_mode),
        .wdt_enable    (wdt_enable),
        .bor_sw_enable (bor_sw_enable)
    );

    // Read port shows the flag register directly.
    always_comb rd_data = flag_q;
endmodule

// File: rtl/rcause_status_chk.sv
// Checker for rcause_status: temporal properties on its ports, bound below.
module rcause_status_chk
    import rcause_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             evt_por,
    input logic             evt_bor,
    input logic             evt_pin_rst,
    input logic             evt_sw_rst,
    input logic             evt_wdt_expire,
    input logic             evt_trap_clash,
    input logic             evt_bad_opcode,
    input logic             evt_cfg_mismatch,
    input logic             evt_power_save,
    input logic             power_save_mode,
    input logic             evt_wdt_kick,
    input logic [1:0]       cfg_wdt_mode,
    input logic [1:0]       cfg_bor_mode,
    input logic             wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic             wdt_enable,
    input logic             bor_sw_enable
);
    logic any_evt;
    always_comb any_evt = evt_bor | evt_pin_rst | evt_sw_rst | evt_wdt_expire |
                          evt_trap_clash | evt_bad_opcode | evt_cfg_mismatch |
                          evt_power_save | evt_wdt_kick;

    assert_por_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_por |=> rd_data == POR_VALUE);

    assert_bor_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_bor && !evt_por) |=> rd_data[B_BOR]);

    assert_trap_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_trap_clash && !evt_por) |=> rd_data[B_TRAP]);

    assert_wdt_expire_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wdt_expire && !evt_por) |=> rd_data[B_WDTO]);

    assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wdt_kick && !evt_wdt_expire && !evt_por) |=> !rd_data[B_WDTO]);

    assert_sleep_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_power_save && !power_save_mode && !evt_por) |=> rd_data[B_SLEEP]);

    assert_idle_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_power_save && power_save_mode && !evt_por) |=> rd_data[B_IDLE]);

    assert_unimpl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~IMPL_MASK) == '0);

    assert_wdt_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wdt_mode == WDT_CFG_FORCE) |-> wdt_enable);

    assert_bor_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bor_mode != BOR_CFG_SW) |-> !bor_sw_enable);

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_evt && !wr_en && !evt_por) |=> $stable(rd_data));
endmodule

bind rcause_status rcause_status_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .evt_por          (evt_por),
    .evt_bor          (evt_bor),
    .evt_pin_rst      (evt_pin_rst),
    .evt_sw_rst       (evt_sw_rst),
    .evt_wdt_expire   (evt_wdt_expire),
    .evt_trap_clash   (evt_trap_clash),
    .evt_bad_opcode   (evt_bad_opcode),
    .evt_cfg_mismatch (evt_cfg_mismatch),
    .evt_power_save   (evt_power_save),
    .power_save_mode  (power_save_mode),
    .evt_wdt_kick     (evt_wdt_kick),
    .cfg_wdt_mode     (cfg_wdt_mode),
    .cfg_bor_mode     (cfg_bor_mode),
    .wr_en            (wr_en),
    .rd_data          (rd_data),
    .wdt_enable       (wdt_enable),
    .bor_sw_enable    (bor_sw_enable)
);

// File: tb/rcause_status_tb.sv
// Directed bench for rcause_status: one task per scenario, each checking its results.
module rcause_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_por = 0, evt_bor = 0, evt_pin_rst = 0, evt_sw_rst = 0;
    logic        evt_wdt_expire = 0, evt_trap_clash = 0, evt_bad_opcode = 0;
    logic        evt_cfg_mismatch = 0, evt_power_save = 0, power_save_mode = 0;
    logic        evt_wdt_kick = 0;
    logic [1:0]  cfg_wdt_mode = 2'b00, cfg_bor_mode = 2'b00;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        wdt_enable, bor_sw_enable;

    int n_tests = 0;
    int n_fail  = 0;
    bit timed_out = 0;

    always #2.5 clk = ~clk;

    rcause_status u_dut (
        .clk(clk), .rst_n(rst_n), .evt_por(evt_por), .evt_bor(evt_bor),
        .evt_pin_rst(evt_pin_rst), .evt_sw_rst(evt_sw_rst),
        .evt_wdt_expire(evt_wdt_expire), .evt_trap_clash(evt_trap_clash),
        .evt_bad_opcode(evt_bad_opcode), .evt_cfg_mismatch(evt_cfg_mismatch),
        .evt_power_save(evt_power_save), .power_save_mode(power_save_mode),
        .evt_wdt_kick(evt_wdt_kick), .cfg_wdt_mode(cfg_wdt_mode),
        .cfg_bor_mode(cfg_bor_mode), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wdt_enable(wdt_enable), .bor_sw_enable(bor_sw_enable)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    // Advance one edge; inputs set before this are seen at that edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        evt_por = 0; evt_bor = 0; evt_pin_rst = 0; evt_sw_rst = 0;
        evt_wdt_expire = 0; evt_trap_clash = 0; evt_bad_opcode = 0;
        evt_cfg_mismatch = 0; evt_power_save = 0; power_save_mode = 0;
        evt_wdt_kick = 0; wr_en = 0;
    endtask

    task automatic sw_write(input logic [15:0] d);
        wr_en = 1; wr_data = d; tick(); idle_inputs();
    endtask

    task automatic t_reset();
        check("R1 reset value", rd_data, 16'h0003);
        check("R9 wdt off after reset", {15'b0, wdt_enable}, 16'h0000);
        tick();
        check("R12 hold with no input", rd_data, 16'h0003);
    endtask

    task automatic t_bor();
        sw_write(16'h0000);
        check("R6 write zero", rd_data, 16'h0000);
        evt_bor = 1; tick(); idle_inputs();
        check("R2 brown-out bit only", rd_data, 16'h0002);
    endtask

    task automatic t_causes();
        sw_write(16'h0000); evt_trap_clash = 1; tick(); idle_inputs();
        check("R3 trap bit 15", rd_data, 16'h8000);
        sw_write(16'h0000); evt_bad_opcode = 1; tick(); idle_inputs();
        check("R3 bad opcode bit 14", rd_data, 16'h4000);
        sw_write(16'h0000); evt_cfg_mismatch = 1; tick(); idle_inputs();
        check("R3 cfg mismatch bit 9", rd_data, 16'h0200);
        sw_write(16'h0000); evt_pin_rst = 1; tick(); idle_inputs();
        check("R3 pin reset bit 7", rd_data, 16'h0080);
        evt_sw_rst = 1; tick(); idle_inputs();
        check("R3 sw reset bit 6 sticky with bit 7", rd_data, 16'h00C0);
    endtask

    task automatic t_wdt();
        sw_write(16'h0000); evt_wdt_expire = 1; tick(); idle_inputs();
        check("R4 expire sets bit 4", rd_data, 16'h0010);
        evt_wdt_kick = 1; tick(); idle_inputs();
        check("R4 kick clears bit 4", rd_data, 16'h0000);
        evt_wdt_expire = 1; evt_wdt_kick = 1; tick(); idle_inputs();
        check("R4 expire beats kick", rd_data, 16'h0010);
        evt_power_save = 1; power_save_mode = 0; tick(); idle_inputs();
        check("R4 R5 sleep clears bit 4 sets bit 3", rd_data, 16'h0008);
    endtask

    task automatic t_power_save();
        evt_power_save = 1; power_save_mode = 1; tick(); idle_inputs();
        check("R5 idle sets bit 2 keeps bit 3", rd_data, 16'h000C);
    endtask

    task automatic t_write();
        sw_write(16'hFFFF);
        check("R8 only implemented bits written", rd_data, 16'hE2FF);
        sw_write(16'h1D00);
        check("R8 unimplemented bits ignore write", rd_data, 16'h0000);
        sw_write(16'h0000); evt_sw_rst = 1; tick(); idle_inputs();
        sw_write(16'h0041);
        check("R6 writing bit 0 leaves others", rd_data, 16'h0041);
    endtask

    task automatic t_conflict();
        sw_write(16'hFFFF);
        wr_en = 1; wr_data = 16'h0000; evt_pin_rst = 1; tick(); idle_inputs();
        check("R7 hw set beats write", rd_data, 16'h0080);
    endtask

    task automatic t_cfg();
        for (int m = 0; m < 4; m++) begin
            cfg_wdt_mode = m[1:0]; cfg_bor_mode = m[1:0];
            sw_write(16'h0000);
            check("R9 wdt enable with bit5=0", {15'b0, wdt_enable}, (m == 3) ? 16'h1 : 16'h0);
            check("R10 bor enable with bit13=0", {15'b0, bor_sw_enable}, 16'h0);
            sw_write(16'h2020);
            check("R9 wdt enable with bit5=1", {15'b0, wdt_enable}, 16'h1);
            check("R10 bor enable with bit13=1", {15'b0, bor_sw_enable}, (m == 1) ? 16'h1 : 16'h0);
        end
        cfg_wdt_mode = 2'b00; cfg_bor_mode = 2'b00;
    endtask

    task automatic t_por();
        sw_write(16'hE2FF);
        evt_por = 1; wr_en = 1; wr_data = 16'hFFFF; evt_trap_clash = 1; tick(); idle_inputs();
        check("R1 power-on event overrides all", rd_data, 16'h0003);
        check("R11 read shows state", rd_data, 16'h0003);
        sw_write(16'h0000);
        rst_n = 0; tick(); rst_n = 1;
        check("R1 rst_n reloads value", rd_data, 16'h0003);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        fork
            begin
                t_reset(); t_bor(); t_causes(); t_wdt(); t_power_save();
                t_write(); t_conflict(); t_cfg(); t_por();
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule